// File: doc/BRIEF.md
# Frame-Aligned Dual Sample Rate Strobe Generator

This block produces the sample/conversion strobes for an audio channel and a telecom channel. Each strobe stays in lock-step with a matching counter in an external codec. Both sides run on the serial bit clock. Each channel first divides that clock by a fixed prescale of 32. It then counts down from a programmable modulus. A one-cycle strobe fires each time the count wraps through zero, so the strobe period is 32 × divisor serial clocks. With a divisor of 12 the period is 384.

Counting must begin at the same instant in this block and in the codec. For that reason, enabling a channel only arms it. The prescaler and the down-counter start on the first frame-sync pulse after the enable. The modulus is reloaded when the channel is enabled and each time the count reaches zero. A divisor write therefore changes the rate only from the next reload onwards.

Each channel has a divisor register with its own legal range: 6 to 127 for audio and 16 to 127 for telecom. A write outside the range is clamped to the nearer bound and sets a sticky error flag for that channel. The two channels share the clock and the frame-sync input and are otherwise independent.

Top module: `srate_sync_top`

## Requirements
- R1: After reset both strobes and both error flags are 0, the audio divisor reads 6 and the telecom divisor reads 16.
- R2: A divisor write inside the channel's legal range (audio 6..127, telecom 16..127; write data 8 bits) is visible on that channel's divisor output on the cycle after the write, unchanged, and leaves its error flag as it was.
- R3: A write below the minimum stores the minimum. A write above 127 stores 127. Either case sets that channel's error flag, which stays 1 until reset.
- R4: After a channel is enabled it produces no strobe until frame-sync is sampled high. Its first strobe is high in the cycle that follows the 32×D-th rising edge after the edge that sampled frame-sync.
- R5: While enabled, strobes repeat every 32×D serial clocks, and each strobe is exactly one cycle wide.
- R6: With the enable low, a channel produces no strobe, and frame-sync pulses do not start it. Raising the enable again re-arms the channel, which then waits for the next frame-sync.
- R7: A divisor write while counting does not alter the period in progress. The new value sets the period from the next one onwards.
- R8: A frame-sync pulse while a channel is already counting does not restart or shift its strobe sequence.
- R9: The channels are independent: the telecom strobe stays low while its enable is low, even when audio is running, and with a divisor of 16 its period is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse, one clock wide |
| aud_en | input | 1 | Audio channel enable |
| aud_wr | input | 1 | Audio divisor write strobe |
| aud_wdata | input | 8 | Audio divisor write value |
| tel_en | input | 1 | Telecom channel enable |
| tel_wr | input | 1 | Telecom divisor write strobe |
| tel_wdata | input | 8 | Telecom divisor write value |
| aud_strobe | output | 1 | Audio sample/conversion strobe |
| tel_strobe | output | 1 | Telecom sample/conversion strobe |
| aud_div | output | 7 | Current audio divisor |
| tel_div | output | 7 | Current telecom divisor |
| aud_err | output | 1 | Sticky audio range error |
| tel_err | output | 1 | Sticky telecom range error |

## Verification
Several properties are checked on every cycle: the stored divisor stays inside its bounds, an out-of-range write is clamped, the error flag never drops, a strobe lasts a single cycle, a disabled channel stays quiet, and counting only begins on a cycle in which an armed channel saw frame-sync. The bench scenarios are the only way to show the cycle-exact period of 32×D and the latency to the first strobe after frame-sync. The same holds for the deferred effect of a divisor write, the immunity to extra frame-sync pulses, and re-arming after a disable.

// File: rtl/srate_pkg.sv
package srate_pkg;
    localparam int unsigned PRESCALE_DEF = 32;
    localparam int unsigned DIV_W_DEF    = 7;
    localparam int unsigned WR_W_DEF     = 8;
    localparam int unsigned AUD_MIN_DEF  = 6;
    localparam int unsigned TEL_MIN_DEF  = 16;
    localparam int unsigned DIV_MAX_DEF  = 127;
    localparam int unsigned NCH          = 2;

    typedef enum logic [0:0] {
        CH_AUDIO   = 1'b0,
        CH_TELECOM = 1'b1
    } chan_id_e;
endpackage

// File: rtl/srate_divreg.sv
module srate_divreg #(
    parameter int unsigned WR_W  = 8,
    parameter int unsigned DIV_W = 7,
    parameter int unsigned MIN   = 6,
    parameter int unsigned MAX   = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WR_W-1:0]  wdata,
    output logic [DIV_W-1:0] div,
    output logic             err
);
    localparam logic [WR_W-1:0]  LO_W = WR_W'(MIN);
    localparam logic [WR_W-1:0]  HI_W = WR_W'(MAX);
    localparam logic [DIV_W-1:0] LO_D = DIV_W'(MIN);
    localparam logic [DIV_W-1:0] HI_D = DIV_W'(MAX);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             err;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (wdata < LO_W) begin
                st_d.div = LO_D;
                st_d.err = 1'b1;
            end else if (wdata > HI_W) begin
                st_d.div = HI_D;
                st_d.err = 1'b1;
            end else begin
                st_d.div = wdata[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div <= LO_D;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div = st_q.div;
    assign err = st_q.err;

    // R3: stored value never leaves the legal window
    a_r3_div_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (div >= LO_D) && (div <= HI_D));

    // R3: error flag is sticky
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R3: low writes clamp to minimum and flag
    a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata < LO_W)) |=> ((div == LO_D) && err));

    // R3: high writes clamp to maximum and flag
    a_r3_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata > HI_W)) |=> ((div == HI_D) && err));

    // R2: legal write is stored as written
    a_r2_store_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata >= LO_W) && (wdata <= HI_W)) |=> (div == $past(wdata[DIV_W-1:0])));
endmodule

// File: rtl/srate_prescale.sv
module srate_prescale #(
    parameter int unsigned PRE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PRE_W = (PRE > 1) ? $clog2(PRE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || (cnt_q == LAST)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R5: prescaler restarts from zero whenever stopped
    a_r5_pre_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/srate_chan.sv
module srate_chan #(
    parameter int unsigned PRE   = 32,
    parameter int unsigned DIV_W = 7,
    parameter int unsigned MAX   = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fsync,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
    localparam logic [DIV_W-1:0] HI_D = DIV_W'(MAX);

    typedef struct packed {
        logic             armed;
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic             strobe;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick;

    srate_prescale #(.PRE(PRE)) pre_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.run),
        .tick (tick)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (!en) begin
            st_d.armed = 1'b0;
            st_d.run   = 1'b0;
            st_d.cnt   = div;
        end else if (!st_q.run && !st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.cnt   = div;
        end else if (st_q.armed) begin
            if (fsync) begin
                st_d.armed = 1'b0;
                st_d.run   = 1'b1;
            end
        end else if (tick) begin
            if (st_q.cnt == ONE) begin
                st_d.cnt    = div;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed  <= 1'b0;
            st_q.run    <= 1'b0;
            st_q.cnt    <= div;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;

    // R5: each strobe lasts one cycle
    a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R5: counter never sits at zero nor above the maximum
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) && (st_q.cnt <= HI_D));

    // R6: disabled channel goes quiet and stops
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!strobe && !st_q.run));

    // R4: counting only starts from an armed state on frame-sync
    a_r4_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> ($past(fsync) && $past(st_q.armed) && $past(en)));

    // R4: never armed and running together
    a_r4_arm_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.armed && st_q.run));
endmodule

// File: rtl/srate_sync_top.sv
module srate_sync_top #(
    parameter int unsigned PRESCALE = srate_pkg::PRESCALE_DEF,
    parameter int unsigned DIV_W    = srate_pkg::DIV_W_DEF,
    parameter int unsigned WR_W     = srate_pkg::WR_W_DEF,
    parameter int unsigned AUD_MIN  = srate_pkg::AUD_MIN_DEF,
    parameter int unsigned TEL_MIN  = srate_pkg::TEL_MIN_DEF,
    parameter int unsigned DIV_MAX  = srate_pkg::DIV_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             aud_en,
    input  logic             aud_wr,
    input  logic [WR_W-1:0]  aud_wdata,
    input  logic             tel_en,
    input  logic             tel_wr,
    input  logic [WR_W-1:0]  tel_wdata,
    output logic             aud_strobe,
    output logic             tel_strobe,
    output logic [DIV_W-1:0] aud_div,
    output logic [DIV_W-1:0] tel_div,
    output logic             aud_err,
    output logic             tel_err
);
    import srate_pkg::*;

    logic [NCH-1:0]   en_v, wr_v, strobe_v, err_v;
    logic [WR_W-1:0]  wdata_v [NCH];
    logic [DIV_W-1:0] div_v   [NCH];

    assign en_v                = {tel_en, aud_en};
    assign wr_v                = {tel_wr, aud_wr};
    assign wdata_v[CH_AUDIO]   = aud_wdata;
    assign wdata_v[CH_TELECOM] = tel_wdata;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int unsigned LO = (g == int'(CH_AUDIO)) ? AUD_MIN : TEL_MIN;

        srate_divreg #(
            .WR_W (WR_W),
            .DIV_W(DIV_W),
            .MIN  (LO),
            .MAX  (DIV_MAX)
        ) reg_i (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (wr_v[g]),
            .wdata(wdata_v[g]),
            .div  (div_v[g]),
            .err  (err_v[g])
        );

        srate_chan #(
            .PRE  (PRESCALE),
            .DIV_W(DIV_W),
            .MAX  (DIV_MAX)
        ) chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[g]),
            .fsync (fsync),
            .div   (div_v[g]),
            .strobe(strobe_v[g])
        );
    end

    assign aud_strobe = strobe_v[CH_AUDIO];
    assign tel_strobe = strobe_v[CH_TELECOM];
    assign aud_div    = div_v[CH_AUDIO];
    assign tel_div    = div_v[CH_TELECOM];
    assign aud_err    = err_v[CH_AUDIO];
    assign tel_err    = err_v[CH_TELECOM];

    // R9: a disabled telecom channel stays silent whatever audio does
    a_r9_tel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tel_en |=> !tel_strobe);
endmodule

// File: tb/srate_sync_top_tb_top.sv
module srate_sync_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       aud_en = 1'b0, aud_wr = 1'b0, tel_en = 1'b0, tel_wr = 1'b0;
    logic [7:0] aud_wdata = '0, tel_wdata = '0;
    logic       aud_strobe, tel_strobe, aud_err, tel_err;
    logic [6:0] aud_div, tel_div;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int tel_stray = 0;

    always #5 clk = ~clk;

    srate_sync_top dut_i (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .aud_en(aud_en), .aud_wr(aud_wr), .aud_wdata(aud_wdata),
        .tel_en(tel_en), .tel_wr(tel_wr), .tel_wdata(tel_wdata),
        .aud_strobe(aud_strobe), .tel_strobe(tel_strobe),
        .aud_div(aud_div), .tel_div(tel_div),
        .aud_err(aud_err), .tel_err(tel_err)
    );

    always @(negedge clk) if (rst_n && !tel_en && tel_strobe) tel_stray++;

    // {channel, write value, expected divisor, expected error}
    localparam logic [16:0] VEC [11] = '{
        {1'b0, 8'd12,  7'd12,  1'b0},
        {1'b0, 8'd6,   7'd6,   1'b0},
        {1'b0, 8'd127, 7'd127, 1'b0},
        {1'b1, 8'd16,  7'd16,  1'b0},
        {1'b1, 8'd127, 7'd127, 1'b0},
        {1'b0, 8'd5,   7'd6,   1'b1},
        {1'b1, 8'd15,  7'd16,  1'b1},
        {1'b0, 8'd200, 7'd127, 1'b1},
        {1'b0, 8'd40,  7'd40,  1'b1},
        {1'b1, 8'd255, 7'd127, 1'b1},
        {1'b1, 8'd20,  7'd20,  1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_div(input bit ch, input logic [7:0] v);
        @(negedge clk);
        if (ch) begin tel_wr = 1'b1; tel_wdata = v; end
        else    begin aud_wr = 1'b1; aud_wdata = v; end
        @(negedge clk);
        aud_wr = 1'b0; tel_wr = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
    endtask

    task automatic count_quiet(input bit ch, input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (ch ? tel_strobe : aud_strobe) seen++;
        end
    endtask

    // counts negedges until the selected strobe is seen; can inject a sync or an audio write
    task automatic next_strobe(input bit ch, input int fs_at, input int wr_at,
                               input logic [7:0] wv, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            fsync = (n == fs_at);
            aud_wr = (n == wr_at);
            if (n == wr_at) aud_wdata = wv;
        end while (!(ch ? tel_strobe : aud_strobe) && n < 5000);
        fsync = 1'b0;
        aud_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int seen;
        do_reset();
        // R1
        chk(!aud_strobe && !tel_strobe, "R1 strobes", aud_strobe + tel_strobe, 0);
        chk(!aud_err && !tel_err, "R1 errors", aud_err + tel_err, 0);
        chk(aud_div == 7'd6, "R1 audio divisor", aud_div, 6);
        chk(tel_div == 7'd16, "R1 telecom divisor", tel_div, 16);

        // R2 / R3 table
        for (int i = 0; i < 11; i++) begin
            logic [16:0] e;
            e = VEC[i];
            write_div(e[16], e[15:8]);
            if (e[16]) begin
                chk(tel_div == e[7:1], e[0] ? "R3 telecom divisor" : "R2 telecom divisor", tel_div, e[7:1]);
                chk(tel_err == e[0], "R3 telecom error", tel_err, e[0]);
            end else begin
                chk(aud_div == e[7:1], e[0] ? "R3 audio divisor" : "R2 audio divisor", aud_div, e[7:1]);
                chk(aud_err == e[0], "R3 audio error", aud_err, e[0]);
            end
        end

        // R3: flags clear only by reset
        do_reset();
        chk(!aud_err && !tel_err, "R3 reset clears error", aud_err + tel_err, 0);

        // R4: armed but waiting for sync
        write_div(1'b0, 8'd12);
        @(negedge clk); aud_en = 1'b1;
        count_quiet(1'b0, 1000, seen);
        chk(seen == 0, "R4 no strobe before sync", seen, 0);
        pulse_sync();
        next_strobe(1'b0, 0, 0, 8'd0, n);
        chk(n == 384, "R4 first strobe latency", n, 384);

        // R5
        next_strobe(1'b0, 0, 0, 8'd0, n);
        chk(n == 384, "R5 period", n, 384);
        next_strobe(1'b0, 0, 0, 8'd0, n);
        chk(n == 384, "R5 period repeat", n, 384);

        // R8
        next_strobe(1'b0, 100, 0, 8'd0, n);
        chk(n == 384, "R8 sync while running", n, 384);

        // R7
        next_strobe(1'b0, 0, 50, 8'd8, n);
        chk(n == 384, "R7 old period kept", n, 384);
        chk(aud_div == 7'd8, "R7 new divisor stored", aud_div, 8);
        next_strobe(1'b0, 0, 0, 8'd0, n);
        chk(n == 256, "R7 new period", n, 256);

        // R6
        @(negedge clk); aud_en = 1'b0;
        count_quiet(1'b0, 400, seen);
        pulse_sync();
        begin
            int s2;
            count_quiet(1'b0, 600, s2);
            seen += s2;
        end
        chk(seen == 0, "R6 disabled quiet", seen, 0);
        @(negedge clk); aud_en = 1'b1;
        count_quiet(1'b0, 600, seen);
        chk(seen == 0, "R6 rearm waits for sync", seen, 0);
        pulse_sync();
        next_strobe(1'b0, 0, 0, 8'd0, n);
        chk(n == 256, "R6 restart after rearm", n, 256);

        // R9
        chk(tel_stray == 0, "R9 telecom quiet while disabled", tel_stray, 0);
        @(negedge clk); tel_en = 1'b1;
        pulse_sync();
        next_strobe(1'b1, 0, 0, 8'd0, n);
        chk(n == 512, "R9 telecom first period", n, 512);
        next_strobe(1'b1, 0, 0, 8'd0, n);
        chk(n == 512, "R9 telecom period", n, 512);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule